// File: doc/BRIEF.md
# Completion Coalescing Interrupt Controller

This block merges bursts of command-completion events from a set of storage ports into fewer interrupts. A host sees one interrupt for a group of completions rather than one for each. Two triggers raise a coalesced interrupt: a count of completions on the selected ports, and a millisecond timeout. The timeout runs only while a selected port still has work outstanding, so an idle controller never fires on the timer.

Software programs a 32-bit control word. It holds a timeout in milliseconds, a completion threshold, the index of the interrupt-status bit to raise, and an enable. Timeout and threshold take effect only when a write sets the enable bit. Clearing the enable silences the block. A port-select mask chooses which ports take part. Each coalesced interrupt is a one-cycle pulse and also sets the chosen bit in a 32-bit status register, which software clears by writing ones.

Top module: `cmpl_coalesce_ctrl`

## Requirements
- R1: After reset, `coal_irq` is 0 and `irq_status` is all zeros.
- R2: With the block enabled and a nonzero timeout T, the timer counts one unit on each cycle with `tick_ms` high while at least one port is both busy and selected in `port_mask`. `coal_irq` pulses high for exactly one cycle, on the cycle after the T-th such tick.
- R3: On a tick, the timer holds its value when no selected port is busy, including when only unselected ports are busy. It also holds on any cycle without a tick.
- R4: Each cycle adds the number of set bits of `cmpl_pulse & port_mask` to the completion count. A single one-cycle interrupt is raised in the cycle after the count reaches or crosses a nonzero threshold. Completions on unselected ports are not counted.
- R5: Every coalesced interrupt clears the completion count to 0 and reloads the timer with the timeout, whichever trigger caused it.
- R6: A threshold of 0 disables the count trigger, so only the timer can raise an interrupt.
- R7: A timeout of 0 disables the timer trigger.
- R8: Control word layout: timeout in bits 31:16, threshold in bits 15:8, status-bit select in bits 7:3, enable in bit 0. Bits 2:1 are ignored. A write with bit 0 clear stops all interrupts and clears the count. A write with bit 0 set applies the timeout and threshold from that write, reloads the timer and clears the count.
- R9: An interrupt sets `irq_status` bit number `select`. A `sts_wr_en` write clears the status bits where `sts_wr_data` is 1. When a set and a clear reach the same bit in one cycle, the set wins.
- R10: When the timer and count triggers occur in the same cycle, one pulse is produced and both the timer and the count are reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word value |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| cmpl_pulse | input | NUM_PORTS | Per-port command completion pulses |
| busy_vec | input | NUM_PORTS | Per-port commands-outstanding flags |
| port_mask | input | NUM_PORTS | Ports taking part in coalescing |
| sts_wr_en | input | 1 | Status write-one-to-clear strobe |
| sts_wr_data | input | 32 | Status bits to clear |
| coal_irq | output | 1 | One-cycle coalesced interrupt pulse |
| irq_status | output | 32 | Interrupt status register |

## Verification
The assertions assume that NUM_PORTS is at most 32 and that control writes never arrive in the same cycle as trigger events. A write cycle suppresses any trigger, and the checks on pulse state after an interrupt rely on this. The stimulus drives every control write on a cycle with no ticks and no completions. It changes the busy and mask vectors only between scenarios or on cycles where their effect is checked. It therefore stays inside these assumptions, and every expected pulse cycle follows by counting ticks and completion bits from the last write.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  localparam int TV_W  = 16;
  localparam int CC_W  = 8;
  localparam int SEL_W = 5;
  localparam int CFG_W = 32;
  localparam int POP_W = 6;

  typedef struct packed {
    logic [TV_W-1:0]  timeout;
    logic [CC_W-1:0]  thresh;
    logic [SEL_W-1:0] sel;
    logic [1:0]       rsvd;
    logic             en;
  } ctrl_word_t;

  function automatic logic [POP_W-1:0] pop32(input logic [31:0] v);
    logic [POP_W-1:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + POP_W'(v[i]);
    return n;
  endfunction

  function automatic logic tmr_at_last(input logic [TV_W-1:0] v);
    return v == TV_W'(1);
  endfunction

  function automatic logic cnt_reached(input logic [CC_W:0] sum,
                                       input logic [CC_W-1:0] th);
    return (th != '0) && (sum >= {1'b0, th});
  endfunction
endpackage

// File: rtl/ccc_timeout_timer.sv
module ccc_timeout_timer
  import ccc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TV_W-1:0] load_val,
  input  logic            step,
  output logic            hit,
  output logic [TV_W-1:0] val
);
  logic [TV_W-1:0] val_q;

  assign hit = step && tmr_at_last(val_q);
  assign val = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val_q <= '0;
    else if (load) val_q <= load_val;
    else if (step) val_q <= val_q - TV_W'(1);
  end
endmodule

// File: rtl/ccc_cmpl_counter.sv
module ccc_cmpl_counter
  import ccc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             active,
  input  logic [CC_W-1:0]  thresh,
  input  logic [POP_W-1:0] add,
  output logic             hit,
  output logic [CC_W-1:0]  cnt
);
  logic [CC_W-1:0] cnt_q;
  logic [CC_W:0]   sum;

  assign sum = {1'b0, cnt_q} + (CC_W+1)'(add);
  assign hit = active && cnt_reached(sum, thresh);
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clr || !active || thresh == '0) cnt_q <= '0;
    else                                cnt_q <= sum[CC_W-1:0];
  end
endmodule

// File: rtl/ccc_irq_status.sv
module ccc_irq_status
  import ccc_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [SEL_W-1:0]  set_idx,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_bits,
  output logic [STAT_W-1:0] status
);
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;

  assign set_vec = set_en ? (STAT_W'(1) << set_idx) : '0;
  assign clr_vec = clr_en ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/cmpl_coalesce_ctrl.sv
module cmpl_coalesce_ctrl
  import ccc_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int STAT_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [CFG_W-1:0]     cfg_wr_data,
  input  logic                 tick_ms,
  input  logic [NUM_PORTS-1:0] cmpl_pulse,
  input  logic [NUM_PORTS-1:0] busy_vec,
  input  logic [NUM_PORTS-1:0] port_mask,
  input  logic                 sts_wr_en,
  input  logic [STAT_W-1:0]    sts_wr_data,
  output logic                 coal_irq,
  output logic [STAT_W-1:0]    irq_status
);
  ctrl_word_t       wr_word;
  logic             en_act;
  logic [TV_W-1:0]  tv_act;
  logic [CC_W-1:0]  cc_act;
  logic [SEL_W-1:0] sel_q;

  logic             busy_sel;
  logic [POP_W-1:0] cmpl_n;
  logic             tmr_step;
  logic             tmr_hit;
  logic             cnt_hit;
  logic             fire;
  logic             tmr_load;
  logic [TV_W-1:0]  tmr_val;
  logic [CC_W-1:0]  cnt_val;
  logic             irq_q;

  assign wr_word = ctrl_word_t'(cfg_wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_act <= 1'b0;
      tv_act <= '0;
      cc_act <= '0;
      sel_q  <= '0;
    end else if (cfg_wr_en) begin
      en_act <= wr_word.en;
      sel_q  <= wr_word.sel;
      if (wr_word.en) begin
        tv_act <= wr_word.timeout;
        cc_act <= wr_word.thresh;
      end
    end
  end

  assign busy_sel = |(busy_vec & port_mask);
  assign cmpl_n   = pop32(32'(cmpl_pulse & port_mask));
  assign tmr_step = en_act && !cfg_wr_en && (tv_act != '0) && busy_sel && tick_ms;
  assign fire     = en_act && !cfg_wr_en && (tmr_hit || cnt_hit);
  assign tmr_load = fire || (cfg_wr_en && wr_word.en);

  ccc_timeout_timer u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (cfg_wr_en ? wr_word.timeout : tv_act),
    .step     (tmr_step),
    .hit      (tmr_hit),
    .val      (tmr_val)
  );

  ccc_cmpl_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (fire || cfg_wr_en),
    .active (en_act && !cfg_wr_en),
    .thresh (cc_act),
    .add    (cmpl_n),
    .hit    (cnt_hit),
    .cnt    (cnt_val)
  );

  ccc_irq_status #(.STAT_W(STAT_W)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (fire),
    .set_idx  (sel_q),
    .clr_en   (sts_wr_en),
    .clr_bits (sts_wr_data),
    .status   (irq_status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire;
  end

  assign coal_irq = irq_q;
endmodule

// File: rtl/ccc_chk.sv
module ccc_chk
  import ccc_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              coal_irq,
  input logic [STAT_W-1:0] irq_status,
  input logic              en_act,
  input logic              cfg_wr_en,
  input logic              busy_sel,
  input logic              tick_ms,
  input logic              fire,
  input logic [TV_W-1:0]   tv_act,
  input logic [CC_W-1:0]   cc_act,
  input logic [TV_W-1:0]   tmr_val,
  input logic [CC_W-1:0]   cnt_val,
  input logic [SEL_W-1:0]  sel_q
);
  // R8: a disabled block never produces a pulse
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_act) |=> !coal_irq);

  // R9: a pulse is always accompanied by its status bit
  a_r9_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
    coal_irq |-> irq_status[$past(sel_q)]);

  // R3: with no selected port busy or no tick, the timer does not move
  a_r3_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((!busy_sel || !tick_ms) && !cfg_wr_en && !fire) |=> $stable(tmr_val));

  // R4: the stored count stays below an active nonzero threshold
  a_r4_count_below: assert property (@(posedge clk) disable iff (!rst_n)
    (en_act && cc_act != '0) |-> (cnt_val < cc_act));

  // R2: an armed timer is never zero and never above the timeout
  a_r2_timer_range: assert property (@(posedge clk) disable iff (!rst_n)
    (en_act && tv_act != '0) |-> (tmr_val != '0 && tmr_val <= tv_act));

  // R5: after a pulse the count is clear and the timer is reloaded
  a_r5_reset_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    coal_irq |-> (cnt_val == '0 && tmr_val == tv_act));
endmodule

bind cmpl_coalesce_ctrl ccc_chk #(.STAT_W(STAT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .coal_irq   (coal_irq),
  .irq_status (irq_status),
  .en_act     (en_act),
  .cfg_wr_en  (cfg_wr_en),
  .busy_sel   (busy_sel),
  .tick_ms    (tick_ms),
  .fire       (fire),
  .tv_act     (tv_act),
  .cc_act     (cc_act),
  .tmr_val    (tmr_val),
  .cnt_val    (cnt_val),
  .sel_q      (sel_q)
);

// File: tb/cmpl_coalesce_ctrl_tb_top.sv
module cmpl_coalesce_ctrl_tb_top;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [31:0]   cfg_wr_data = '0;
  logic          tick_ms = 1'b0;
  logic [NP-1:0] cmpl_pulse = '0;
  logic [NP-1:0] busy_vec = '0;
  logic [NP-1:0] port_mask = '0;
  logic          sts_wr_en = 1'b0;
  logic [31:0]   sts_wr_data = '0;
  logic          coal_irq;
  logic [31:0]   irq_status;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cmpl_coalesce_ctrl #(.NUM_PORTS(NP), .STAT_W(32)) dut_i (
    .clk, .rst_n, .cfg_wr_en, .cfg_wr_data, .tick_ms, .cmpl_pulse,
    .busy_vec, .port_mask, .sts_wr_en, .sts_wr_data, .coal_irq, .irq_status
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    check(coal_irq === exp, req, 32'(coal_irq), 32'(exp));
  endtask

  // inputs set after a falling edge apply at the next rising edge;
  // results are read at the following falling edge
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    tick_ms = 1'b0; cmpl_pulse = '0; cfg_wr_en = 1'b0; sts_wr_en = 1'b0;
  endtask

  task automatic write_cfg(input logic [15:0] tv, input logic [7:0] cc,
                           input logic [4:0] sel, input logic en);
    cfg_wr_en = 1'b1;
    cfg_wr_data = {tv, cc, sel, 2'b11, en};
    cycle();
  endtask

  task automatic do_tick(input string req, input logic exp);
    tick_ms = 1'b1; cycle(); chk_irq(req, exp);
  endtask

  task automatic do_cmpl(input logic [NP-1:0] v, input string req, input logic exp);
    cmpl_pulse = v; cycle(); chk_irq(req, exp);
  endtask

  task automatic clear_status();
    sts_wr_en = 1'b1; sts_wr_data = '1; cycle();
  endtask

  task automatic t_reset();
    check(coal_irq === 1'b0, "R1 irq", 32'(coal_irq), 0);
    check(irq_status === 32'h0, "R1 status", irq_status, 0);
  endtask

  task automatic t_timer();
    port_mask = 8'h0F; busy_vec = 8'h01;
    write_cfg(16'd3, 8'd0, 5'd5, 1'b1);
    do_tick("R2 tick1", 1'b0);
    do_tick("R2 tick2", 1'b0);
    do_tick("R2 tick3 fires", 1'b1);
    check(irq_status === 32'h20, "R9 bit5 set", irq_status, 32'h20);
    cycle(); chk_irq("R2 single pulse", 1'b0);
    sts_wr_en = 1'b1; sts_wr_data = 32'h20; cycle();
    check(irq_status === 32'h0, "R9 w1c", irq_status, 0);
  endtask

  task automatic t_hold();
    busy_vec = 8'h10;
    for (int i = 0; i < 5; i++) do_tick("R3 unselected busy", 1'b0);
    busy_vec = 8'h01;
    for (int i = 0; i < 4; i++) begin cycle(); chk_irq("R3 no tick", 1'b0); end
    do_tick("R3 t1", 1'b0);
    do_tick("R3 t2", 1'b0);
    busy_vec = 8'h00;
    for (int i = 0; i < 4; i++) do_tick("R3 idle ticks", 1'b0);
    busy_vec = 8'h02;
    do_tick("R3 resumes fires", 1'b1);
    busy_vec = 8'h00;
    clear_status();
  endtask

  task automatic t_count();
    port_mask = 8'h0F;
    write_cfg(16'd0, 8'd5, 5'd2, 1'b1);
    do_cmpl(8'h03, "R4 two", 1'b0);
    do_cmpl(8'hF0, "R4 unselected", 1'b0);
    do_cmpl(8'h07, "R4 reach five", 1'b1);
    check(irq_status === 32'h4, "R9 bit2", irq_status, 32'h4);
    do_cmpl(8'h0F, "R4 four", 1'b0);
    do_cmpl(8'h0F, "R4 cross", 1'b1);
    cycle(); chk_irq("R4 single pulse", 1'b0);
    do_cmpl(8'h0F, "R4 cleared four", 1'b0);
    sts_wr_en = 1'b1; sts_wr_data = 32'h4;
    do_cmpl(8'h01, "R4 reach again", 1'b1);
    check(irq_status === 32'h4, "R9 set wins", irq_status, 32'h4);
    clear_status();
  endtask

  task automatic t_tv0();
    busy_vec = 8'h01;
    write_cfg(16'd0, 8'd0, 5'd1, 1'b1);
    for (int i = 0; i < 20; i++) do_tick("R7 zero timeout", 1'b0);
    check(irq_status === 32'h0, "R7 status", irq_status, 0);
    busy_vec = 8'h00;
  endtask

  task automatic t_cc0();
    write_cfg(16'd2, 8'd0, 5'd3, 1'b1);
    for (int i = 0; i < 10; i++) do_cmpl(8'h0F, "R6 zero threshold", 1'b0);
    busy_vec = 8'h04;
    do_tick("R6 t1", 1'b0);
    do_tick("R6 timer fires", 1'b1);
    busy_vec = 8'h00;
    clear_status();
  endtask

  task automatic t_both_reset();
    busy_vec = 8'h01;
    write_cfg(16'd4, 8'd3, 5'd7, 1'b1);
    do_cmpl(8'h03, "R5 pre two", 1'b0);
    for (int i = 0; i < 3; i++) do_tick("R5 ticks", 1'b0);
    do_tick("R5 timer fires", 1'b1);
    do_cmpl(8'h03, "R5 count cleared", 1'b0);
    for (int i = 0; i < 3; i++) do_tick("R5 ticks b", 1'b0);
    do_cmpl(8'h01, "R5 count fires", 1'b1);
    for (int i = 0; i < 3; i++) do_tick("R5 timer reloaded", 1'b0);
    do_tick("R5 timer fires again", 1'b1);
    busy_vec = 8'h00;
    clear_status();
  endtask

  task automatic t_simul();
    busy_vec = 8'h01;
    write_cfg(16'd2, 8'd2, 5'd9, 1'b1);
    do_tick("R10 t1", 1'b0);
    tick_ms = 1'b1; cmpl_pulse = 8'h03; cycle();
    chk_irq("R10 joint fire", 1'b1);
    cycle(); chk_irq("R10 one pulse", 1'b0);
    do_tick("R10 timer reset", 1'b0);
    do_cmpl(8'h01, "R10 count reset", 1'b0);
    check(irq_status === 32'h200, "R10 status", irq_status, 32'h200);
    busy_vec = 8'h00;
    clear_status();
  endtask

  task automatic t_enable();
    busy_vec = 8'h01;
    write_cfg(16'd1, 8'd1, 5'd4, 1'b0);
    do_cmpl(8'h01, "R8 off cmpl", 1'b0);
    do_tick("R8 off tick", 1'b0);
    check(irq_status === 32'h0, "R8 status off", irq_status, 0);
    write_cfg(16'd0, 8'd2, 5'd4, 1'b1);
    do_cmpl(8'h01, "R8 applied threshold", 1'b0);
    do_tick("R8 applied timeout", 1'b0);
    do_cmpl(8'h01, "R8 fires at two", 1'b1);
    busy_vec = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_hold();
    t_count();
    t_tv0();
    t_cc0();
    t_both_reset();
    t_simul();
    t_enable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule